// File: doc/BRIEF.md
# Copy-by-Reference Line Indexing Table

This block turns a memory copy into a remapping step. A copy command names a source address, a destination address and a byte length. Instead of moving bytes, the block writes one table entry for each cache line of the destination. Each entry records that the destination line can currently be served by the cache line that already holds the matching source data. A read of a destination address is looked up in the table. On a hit, the block returns the cache index of the source line, and the surrounding cache reads that line in place of the destination.

The real data movement is put off until one side of the copy is written. A write that lands on a tracked destination line, or on a source line that some entry points at, clears the affected entries. It then asks the memory side to write the source line back, and after that to refill the written line. The surrounding cache is assumed to be write-back with write-allocate, so the refill brings in the correct line for the pending write to merge into. The triggering write is not acknowledged until the refill request has been accepted.

Top module: `lazy_copy_table`

## Requirements
- R1: After reset every table entry is invalid, so all lookups miss. After reset `busy` and `mem_valid` are low and `cmd_ready` is high.
- R2: An entry is selected by the index bits of the destination line number (address bits [14:6] by default). A lookup hits only when that entry is valid and its stored tag equals the requested address's tag (bits [31:15]). On a hit, `lk_ptr` gives the stored 9-bit source line index.
- R3: An accepted copy of N bytes (N a multiple of 64, from 64 to 32768) fills N/64 entries for consecutive destination lines. Destination line k points at source line k. Each entry takes 2 cycles to fill, so `busy` stays high for exactly 2·N/64 cycles.
- R4: A command is rejected in these cases: the length exceeds 32768 bytes, the length is zero, the length is not a multiple of 64, or either address is not 64-byte aligned. A rejected command is accepted on the handshake, gives a one-cycle `cmd_err` pulse in the cycle after acceptance, and leaves the table unchanged.
- R5: A command whose source and destination line ranges overlap is rejected the same way, with a `cmd_err` pulse and no change to the table.
- R6: While a fill or a write sequence is in progress, `lk_ready` is low and no lookup reports a hit.
- R7: A write to a tracked destination line invalidates that entry. Exactly 2 cycles after the write is accepted, the block raises a write-back request (`mem_wb`=1) whose `mem_line` is the source index the entry held. Once that request is accepted, it raises a refill request (`mem_wb`=0) for the written line number. `wr_ready` rises only together with the refill handshake.
- R8: A write whose line index equals the source index stored in any valid entry invalidates every such entry. It then issues a write-back of that index and a refill of the written line, with the same timing as R7.
- R9: A write that touches no valid entry is acknowledged in the same cycle, with no memory request.
- R10: A memory request stays valid, and its `mem_line` and `mem_wb` stay unchanged, until `mem_ready` is seen.
- R11: While `wr_valid` is high, `cmd_ready` is low, so a pending write is served before a copy command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Copy command present |
| cmd_ready | output | 1 | Copy command accepted this cycle when valid |
| cmd_src | input | 32 | Source byte address |
| cmd_dst | input | 32 | Destination byte address |
| cmd_len | input | 20 | Copy length in bytes |
| cmd_err | output | 1 | One-cycle pulse: last command rejected |
| busy | output | 1 | Table fill in progress |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Destination byte address to look up |
| lk_ready | output | 1 | Lookup served this cycle |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_ptr | output | 9 | Source line cache index on a hit |
| wr_valid | input | 1 | Write notification, held until acknowledged |
| wr_addr | input | 32 | Byte address being written |
| wr_ready | output | 1 | Write acknowledged |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory side accepts request |
| mem_wb | output | 1 | 1 = write-back of a source index, 0 = refill of a line |
| mem_line | output | 26 | Line number for refill; zero-extended source index for write-back |

## Verification
The bench targets the edges of the length check: a copy of exactly 512 lines must fill, and one line more must be rejected. A design with an off-by-one limit would either fill past the table or refuse the largest legal copy. It also checks that a rejected or overlapping command leaves earlier mappings intact, and a design that partly filled before the check would lose hits. For writes, the bench covers a source line shared by two copies, where a design that clears only the first match would keep a stale pointer. It also measures the exact penalty before the write-back and checks that the write-back comes before the refill and that the acknowledge arrives with the refill. A wrong pointer in the write-back would send the wrong line to memory.

// File: rtl/lazy_copy_table.sv
`timescale 1ns/1ps
module lazy_copy_table #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LINES      = 512,
  parameter int LEN_W      = 20,
  parameter int FILL_CYC   = 2,
  parameter int WR_PEN     = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cmd_valid,
  output logic                                   cmd_ready,
  input  logic [ADDR_W-1:0]                      cmd_src,
  input  logic [ADDR_W-1:0]                      cmd_dst,
  input  logic [LEN_W-1:0]                       cmd_len,
  output logic                                   cmd_err,
  output logic                                   busy,
  input  logic                                   lk_valid,
  input  logic [ADDR_W-1:0]                      lk_addr,
  output logic                                   lk_ready,
  output logic                                   lk_hit,
  output logic [$clog2(LINES)-1:0]               lk_ptr,
  input  logic                                   wr_valid,
  input  logic [ADDR_W-1:0]                      wr_addr,
  output logic                                   wr_ready,
  output logic                                   mem_valid,
  input  logic                                   mem_ready,
  output logic                                   mem_wb,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]   mem_line
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int CNT_W  = IDX_W + 1;
  localparam int NL_W   = LEN_W - OFF_W;
  localparam logic [LEN_W:0] MAX_LEN   = (LEN_W+1)'(LINES * LINE_BYTES);
  localparam logic [7:0]     FILL_LAST = 8'(FILL_CYC - 1);
  localparam logic [7:0]     PEN_LAST  = 8'(WR_PEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_PEN, S_WB, S_RF} st_t;
  st_t st;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [IDX_W-1:0] src_mem [LINES];

  logic [7:0]        tick;
  logic [LINE_W-1:0] f_src, f_dst;
  logic [CNT_W-1:0]  f_rem;
  logic [IDX_W-1:0]  wb_idx;
  logic [LINE_W-1:0] rf_line;

  wire idle = (st == S_IDLE);
  wire unused_bits = ^{lk_addr[OFF_W-1:0], wr_addr[OFF_W-1:0]};

  // lookup path
  wire [LINE_W-1:0] lk_line = lk_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0]  lk_i    = lk_line[IDX_W-1:0];
  wire [TAG_W-1:0]  lk_t    = lk_line[LINE_W-1:IDX_W];

  assign lk_ready = idle;
  assign lk_hit   = lk_valid & idle & vld[lk_i] & (tag_mem[lk_i] == lk_t);
  assign lk_ptr   = src_mem[lk_i];

  // write classification
  wire [LINE_W-1:0] wr_line = wr_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0]  wr_i    = wr_line[IDX_W-1:0];
  wire [TAG_W-1:0]  wr_t    = wr_line[LINE_W-1:IDX_W];
  wire              dst_hit = vld[wr_i] & (tag_mem[wr_i] == wr_t);

  logic [LINES-1:0] src_hit;
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_src_cmp
      assign src_hit[g] = vld[g] & (src_mem[g] == wr_i);
    end
  endgenerate

  wire tracked = dst_hit | (|src_hit);
  wire wr_go   = idle & wr_valid;

  logic [LINES-1:0] clr_mask;
  always_comb begin
    clr_mask = src_hit;
    if (dst_hit) clr_mask[wr_i] = 1'b1;
  end

  // command checking
  wire [LINE_W-1:0] c_src = cmd_src[ADDR_W-1:OFF_W];
  wire [LINE_W-1:0] c_dst = cmd_dst[ADDR_W-1:OFF_W];
  wire [NL_W-1:0]   c_n   = cmd_len[LEN_W-1:OFF_W];

  logic [LINE_W:0] s_x, d_x, n_x;
  always_comb begin
    s_x = {1'b0, c_src};
    d_x = {1'b0, c_dst};
    n_x = (LINE_W+1)'(c_n);
  end

  wire misal   = (|cmd_src[OFF_W-1:0]) | (|cmd_dst[OFF_W-1:0]) | (|cmd_len[OFF_W-1:0]);
  wire too_big = {1'b0, cmd_len} > MAX_LEN;
  wire is_zero = (c_n == '0);
  wire overlap = (s_x < d_x + n_x) && (d_x < s_x + n_x);
  wire bad_cmd = misal | too_big | is_zero | overlap;

  assign cmd_ready = idle & ~wr_valid;
  wire cmd_go = cmd_valid & cmd_ready;

  wire fill_wr = (st == S_FILL) && (tick == FILL_LAST);

  // control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tick    <= '0;
      cmd_err <= 1'b0;
      f_src   <= '0;
      f_dst   <= '0;
      f_rem   <= '0;
      wb_idx  <= '0;
      rf_line <= '0;
    end else begin
      cmd_err <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (wr_go && tracked) begin
            st      <= S_PEN;
            tick    <= '0;
            wb_idx  <= dst_hit ? src_mem[wr_i] : wr_i;
            rf_line <= wr_line;
          end else if (cmd_go) begin
            if (bad_cmd) begin
              cmd_err <= 1'b1;
            end else begin
              st    <= S_FILL;
              tick  <= '0;
              f_src <= c_src;
              f_dst <= c_dst;
              f_rem <= c_n[CNT_W-1:0];
            end
          end
        end
        S_FILL: begin
          if (fill_wr) begin
            tick  <= '0;
            f_src <= f_src + LINE_W'(1);
            f_dst <= f_dst + LINE_W'(1);
            f_rem <= f_rem - CNT_W'(1);
            if (f_rem == CNT_W'(1)) st <= S_IDLE;
          end else begin
            tick <= tick + 8'd1;
          end
        end
        S_PEN: begin
          if (tick == PEN_LAST) st <= S_WB;
          else tick <= tick + 8'd1;
        end
        S_WB: if (mem_ready) st <= S_RF;
        S_RF: if (mem_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // table contents
  always_ff @(posedge clk) begin
    if (fill_wr) begin
      tag_mem[f_dst[IDX_W-1:0]] <= f_dst[LINE_W-1:IDX_W];
      src_mem[f_dst[IDX_W-1:0]] <= f_src[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 vld <= '0;
    else if (fill_wr)           vld[f_dst[IDX_W-1:0]] <= 1'b1;
    else if (wr_go && tracked)  vld <= vld & ~clr_mask;
  end

  assign busy      = (st == S_FILL);
  assign mem_valid = (st == S_WB) | (st == S_RF);
  assign mem_wb    = (st == S_WB);
  assign mem_line  = (st == S_WB) ? LINE_W'(wb_idx) : rf_line;
  assign wr_ready  = (wr_go & ~tracked) | ((st == S_RF) & mem_ready);
endmodule

// File: rtl/lazy_copy_table_chk.sv
`timescale 1ns/1ps
module lazy_copy_table_chk #(
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              cmd_err,
  input logic              busy,
  input logic              lk_ready,
  input logic              lk_hit,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_wb,
  input logic [LINE_W-1:0] mem_line
);
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_line) && $stable(mem_wb));

  a_r7_refill_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_wb && mem_ready |=> mem_valid && !mem_wb);

  a_r7_first_is_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> mem_wb);

  a_r6_lookup_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || mem_valid) |-> !lk_ready && !lk_hit);

  a_r3_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  a_r4_err_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !busy);

  a_r9_no_ack_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !(mem_valid && mem_wb));

  a_r11_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cmd_ready);
endmodule

bind lazy_copy_table lazy_copy_table_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .cmd_err(cmd_err),
  .busy(busy), .lk_ready(lk_ready), .lk_hit(lk_hit), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_wb(mem_wb), .mem_line(mem_line)
);

// File: tb/lazy_copy_table_bench.sv
`timescale 1ns/1ps
module lazy_copy_table_bench;
  localparam int NL = 512;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_ready, cmd_err, busy;
  logic [31:0] cmd_src = 0, cmd_dst = 0;
  logic [19:0] cmd_len = 0;
  logic        lk_valid = 0, lk_ready, lk_hit;
  logic [31:0] lk_addr = 0;
  logic [8:0]  lk_ptr;
  logic        wr_valid = 0, wr_ready;
  logic [31:0] wr_addr = 0;
  logic        mem_valid, mem_ready = 0, mem_wb;
  logic [25:0] mem_line;

  int checks = 0, fails = 0, cyc = 0;
  bit m_vld [NL];
  int m_tag [NL];
  int m_src [NL];

  lazy_copy_table u_lazy_copy_table (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len), .cmd_err(cmd_err),
    .busy(busy), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .lk_hit(lk_hit), .lk_ptr(lk_ptr), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_ready(wr_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_wb(mem_wb), .mem_line(mem_line)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not complete, got %0d cycles expected fewer", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(cmd_ready == 1, "R1", "cmd_ready after reset", cmd_ready, 1);
    chk(busy == 0 && mem_valid == 0, "R1", "busy/mem_valid after reset", {busy, mem_valid}, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); lk_addr = 32'(k * 64 * 97); lk_valid = 1; #1;
      chk(lk_hit == 0, "R1", "lookup after reset", lk_hit, 0);
    end
    lk_valid = 0;
  endtask

  task automatic t_copy(input logic [31:0] s, input logic [31:0] d, input logic [19:0] len,
                        input bit exp_err, input string req);
    int n = 0, bad_stall = 0, exp_n;
    @(negedge clk); cmd_src = s; cmd_dst = d; cmd_len = len; cmd_valid = 1; #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); cmd_valid = 0; lk_valid = 1; lk_addr = d; #1;
    chk(cmd_err == exp_err, req, "cmd_err after command", cmd_err, exp_err);
    while (busy) begin
      if (lk_ready || lk_hit) bad_stall++;
      n++;
      @(negedge clk); #1;
    end
    lk_valid = 0;
    exp_n = exp_err ? 0 : 2 * (int'(len) / 64);
    chk(n == exp_n, exp_err ? req : "R3", "busy cycles", n, exp_n);
    if (!exp_err) begin
      chk(bad_stall == 0, "R6", "lookup served during fill", bad_stall, 0);
      for (int k = 0; k < int'(len) / 64; k++) begin
        int dl = int'(d >> 6) + k;
        m_vld[dl % NL] = 1;
        m_tag[dl % NL] = dl / NL;
        m_src[dl % NL] = (int'(s >> 6) + k) % NL;
      end
    end
  endtask

  task automatic t_look(input logic [31:0] a, input string req);
    int li = int'(a >> 6);
    bit eh = m_vld[li % NL] && (m_tag[li % NL] == li / NL);
    @(negedge clk); lk_addr = a; lk_valid = 1; #1;
    chk(lk_ready == 1 && lk_hit == eh, req, "lookup hit", lk_hit, eh);
    if (eh) chk(int'(lk_ptr) == m_src[li % NL], req, "lookup pointer", int'(lk_ptr), m_src[li % NL]);
    lk_valid = 0;
  endtask

  task automatic t_write(input logic [31:0] a, input string req, input bit also_cmd);
    int li = int'(a >> 6);
    int i = li % NL;
    bit dh = m_vld[i] && (m_tag[i] == li / NL);
    bit any = 0;
    int wbi, n = 0;
    for (int k = 0; k < NL; k++) if (m_vld[k] && m_src[k] == i) any = 1;
    wbi = dh ? m_src[i] : i;
    @(negedge clk); wr_addr = a; wr_valid = 1;
    if (also_cmd) begin cmd_src = 32'h0; cmd_dst = 32'h8000; cmd_len = 20'd64; cmd_valid = 1; end
    #1;
    if (also_cmd) chk(cmd_ready == 0, "R11", "cmd_ready while write pending", cmd_ready, 0);
    if (!(dh || any)) begin
      chk(wr_ready == 1 && mem_valid == 0, "R9", "untracked write ack", {wr_ready, mem_valid}, 2);
      @(posedge clk);
      @(negedge clk); wr_valid = 0; cmd_valid = 0; #1;
      chk(mem_valid == 0, "R9", "no memory request", mem_valid, 0);
      return;
    end
    chk(wr_ready == 0, req, "early ack", wr_ready, 0);
    @(posedge clk);
    @(negedge clk); #1;
    while (!mem_valid && n < 10) begin n++; @(negedge clk); #1; end
    chk(n == 2, req, "penalty cycles", n, 2);
    chk(mem_wb == 1 && int'(mem_line) == wbi, req, "write-back line", int'(mem_line), wbi);
    @(negedge clk); #1;
    chk(mem_valid && mem_wb && int'(mem_line) == wbi, "R10", "request held", int'(mem_line), wbi);
    mem_ready = 1;
    @(posedge clk);
    @(negedge clk); mem_ready = 0; #1;
    chk(mem_valid && !mem_wb && int'(mem_line) == li, req, "refill line", int'(mem_line), li);
    chk(wr_ready == 0, req, "ack before refill handshake", wr_ready, 0);
    mem_ready = 1; #1;
    chk(wr_ready == 1, req, "ack with refill handshake", wr_ready, 1);
    @(posedge clk);
    @(negedge clk); mem_ready = 0; wr_valid = 0; #1;
    chk(mem_valid == 0, req, "sequence ends", mem_valid, 0);
    if (dh) m_vld[i] = 0;
    for (int k = 0; k < NL; k++) if (m_src[k] == i) m_vld[k] = 0;
  endtask

  initial begin
    for (int k = 0; k < NL; k++) begin m_vld[k] = 0; m_tag[k] = 0; m_src[k] = 0; end
    t_reset();
    // four-line copy, then hits, misses beyond and on aliased tag
    t_copy(32'h0000_1000, 32'h0002_0000, 20'd256, 0, "R3");
    for (int k = 0; k < 5; k++) t_look(32'h0002_0000 + 32'(k * 64), "R2");
    t_look(32'h0004_0000, "R2");
    t_look(32'h0000_1000, "R2");
    // rejections must not touch the table
    t_copy(32'h0010_0000, 32'h0020_0000, 20'd32832, 1, "R4");
    t_copy(32'h0010_0000, 32'h0020_0000, 20'd0, 1, "R4");
    t_copy(32'h0010_0000, 32'h0020_0000, 20'd100, 1, "R4");
    t_copy(32'h0010_0010, 32'h0020_0000, 20'd64, 1, "R4");
    t_copy(32'h0000_3000, 32'h0000_3040, 20'd128, 1, "R5");
    t_copy(32'h0000_3040, 32'h0000_3000, 20'd128, 1, "R5");
    for (int k = 0; k < 4; k++) t_look(32'h0002_0000 + 32'(k * 64), "R4");
    // second copy sharing source line index 66
    t_copy(32'h0000_1080, 32'h0003_0400, 20'd64, 0, "R3");
    t_look(32'h0003_0400, "R2");
    // destination write
    t_write(32'h0002_0044, "R7", 0);
    t_look(32'h0002_0040, "R7");
    t_look(32'h0002_0000, "R7");
    // source write clears both entries pointing at index 66
    t_write(32'h0000_1088, "R8", 0);
    t_look(32'h0002_0080, "R8");
    t_look(32'h0003_0400, "R8");
    t_look(32'h0002_00C0, "R8");
    // untracked write with a competing command
    t_write(32'h0000_5000, "R9", 1);
    // largest legal copy
    t_copy(32'h0010_0000, 32'h0020_0000, 20'd32768, 0, "R3");
    t_look(32'h0020_0000, "R3");
    t_look(32'h0020_7FC0, "R3");
    t_look(32'h0002_0000, "R3");
    t_write(32'h0010_0140, "R8", 0);
    t_look(32'h0020_0140, "R8");
    t_write(32'h0020_0180, "R7", 0);
    t_look(32'h0020_0180, "R7");
    t_look(32'h0020_01C0, "R2");
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule